// File: doc/BRIEF.md
# Floating-Point Compare Unit with Condition-Flag Bank

This block compares two IEEE-754 binary operands, either 32-bit or 64-bit as chosen by a per-request precision input, and stores the one-bit outcome in a bank of eight condition flags. It does not write a result register. Branch logic reads the flags through a separate registered read port, which returns the flag named by a read index. A request carries both operands, a test code (less-than, less-or-equal or equal), the index of the flag to write and a valid strobe. Software that has no other preference uses flag 0 by driving index 0 on both the write index and the read index.

Each operand is split into a sign, a biased exponent and a fraction. Zeros of either sign are treated as equal. Any NaN makes every test false. All other values, infinities included, are ordered by sign and then by magnitude.

A two-state controller sequences each request:

- **S_IDLE** waits for a strobe. It leaves through **T_ACCEPT** when a strobe arrives and otherwise stays put through **T_WAIT**.
- **S_COMMIT** writes the captured outcome into the bank. It returns to S_IDLE through **T_DRAIN**. If another strobe is present in the same cycle, it captures that request and stays in S_COMMIT through **T_CHAIN**.

Top module: `fp_compare_flags`

## Requirements
- R1: In 32-bit mode (`in_dbl`=0), each operand's sign is bit 31, its biased exponent is bits 30..23 and its fraction is bits 22..0. Bits 63..32 have no effect on the outcome.
- R2: In 64-bit mode (`in_dbl`=1), each operand's sign is bit 63, its biased exponent is bits 62..52 and its fraction is bits 51..0.
- R3: An operand whose exponent and fraction are all zero is a zero of either sign. +0 and -0 compare equal, so less-than is false and less-or-equal is true.
- R4: An operand with an all-ones exponent and a nonzero fraction is a NaN. If either operand is a NaN, all three tests write 0.
- R5: An all-ones exponent with a zero fraction is an infinity. +inf orders above every finite value and -inf orders below every finite value.
- R6: For non-NaN operands, a negative value orders below a positive value. Two positive values order by their exponent-and-fraction magnitude. Two negative values order by that magnitude in reverse.
- R7: Test code `in_op` selects the test: 0 is less-than (a<b), 1 is less-or-equal (a<=b), 2 is equal (a==b). Code 3 writes 0.
- R8: A request writes only flag `in_flag_idx`. All other flags keep their values, and the flags do not change in any cycle without a request.
- R9: If the strobe is sampled at rising edge k, the written flag shows on `flags` after edge k+1.
- R10: `sel_flag` shows, after each rising edge, the value `flags[rd_idx]` had just before that edge.
- R11: After reset, `flags` and `sel_flag` are zero.
- R12: Strobes on consecutive cycles are all accepted, and each one writes its own flag one edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_dbl | input | 1 | 1 for 64-bit operands, 0 for 32-bit operands |
| in_op | input | 2 | Test code: 0 less-than, 1 less-or-equal, 2 equal |
| in_flag_idx | input | 3 | Flag to write |
| opnd_a | input | 64 | Left operand (low 32 bits in 32-bit mode) |
| opnd_b | input | 64 | Right operand (low 32 bits in 32-bit mode) |
| rd_idx | input | 3 | Flag selected for the read port |
| flags | output | 8 | Whole condition-flag bank |
| sel_flag | output | 1 | Registered copy of the selected flag |

## Verification
The bank write of a committed compare and the registered read of the same flag can fall on one clock edge. The bench provokes this by holding `rd_idx` on the target flag while it issues a compare whose outcome is the opposite of that flag's current value. `sel_flag` is expected to show the old value in the cycle after the commit edge and the new value one cycle later, while `flags` already shows the new value. Two strobes on consecutive cycles are also issued to separate flags, so that one request's commit overlaps the next one's capture.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int WORD_W    = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int MAG_W     = WORD_W - 1;
    localparam int SP_MAG_W  = SP_EXP_W + SP_FRAC_W;

    typedef enum logic [1:0] {
        CMP_LT   = 2'd0,
        CMP_LE   = 2'd1,
        CMP_EQ   = 2'd2,
        CMP_NONE = 2'd3
    } cmp_op_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_COMMIT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             sgn;
        logic             zero;
        logic             nan;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;

endpackage

// File: rtl/fpcmp_field_decode.sv
module fpcmp_field_decode
    import fpcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              dbl,
    output opnd_info_t        info
);
    logic [DP_EXP_W-1:0]  dp_exp;
    logic [DP_FRAC_W-1:0] dp_frac;
    logic [SP_EXP_W-1:0]  sp_exp;
    logic [SP_FRAC_W-1:0] sp_frac;
    logic                 exp_ones;
    logic                 frac_any;

    assign dp_exp  = word[WORD_W-2 -: DP_EXP_W];
    assign dp_frac = word[DP_FRAC_W-1:0];
    assign sp_exp  = word[SP_MAG_W-1 -: SP_EXP_W];
    assign sp_frac = word[SP_FRAC_W-1:0];

    always_comb begin
        if (dbl) begin
            info.sgn = word[WORD_W-1];
            info.mag = word[MAG_W-1:0];
            exp_ones = &dp_exp;
            frac_any = |dp_frac;
        end else begin
            info.sgn = word[SP_MAG_W];
            info.mag = {{(MAG_W-SP_MAG_W){1'b0}}, word[SP_MAG_W-1:0]};
            exp_ones = &sp_exp;
            frac_any = |sp_frac;
        end
        info.zero = (info.mag == '0);
        info.nan  = exp_ones & frac_any;
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_info_t a,
    input  opnd_info_t b,
    input  logic [1:0] op,
    output logic       outcome
);
    cmp_op_e op_e;
    logic    unordered;
    logic    both_zero;
    logic    mag_lt;
    logic    mag_gt;
    logic    is_eq;
    logic    is_lt;

    assign op_e      = cmp_op_e'(op);
    assign unordered = a.nan | b.nan;
    assign both_zero = a.zero & b.zero;
    assign mag_lt    = a.mag < b.mag;
    assign mag_gt    = b.mag < a.mag;

    always_comb begin
        is_eq = !unordered && (both_zero || (a.sgn == b.sgn && a.mag == b.mag));
        is_lt = 1'b0;
        if (!unordered && !both_zero) begin
            unique case ({a.sgn, b.sgn})
                2'b10:   is_lt = 1'b1;
                2'b01:   is_lt = 1'b0;
                2'b00:   is_lt = mag_lt;
                default: is_lt = mag_gt;
            endcase
        end
        unique case (op_e)
            CMP_LT:  outcome = is_lt;
            CMP_LE:  outcome = is_lt | is_eq;
            CMP_EQ:  outcome = is_eq;
            default: outcome = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpcmp_flag_bank.sv
module fpcmp_flag_bank #(
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_bit,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [NUM_FLAGS-1:0] bank,
    output logic                 rd_bit
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                bank[g] <= wr_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bit <= 1'b0;
        end else begin
            rd_bit <= bank[rd_idx];
        end
    end
endmodule

// File: rtl/fp_compare_flags.sv
module fp_compare_flags
    import fpcmp_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_dbl,
    input  logic [1:0]           in_op,
    input  logic [IDX_W-1:0]     in_flag_idx,
    input  logic [WORD_W-1:0]    opnd_a,
    input  logic [WORD_W-1:0]    opnd_b,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 sel_flag
);
    logic [WORD_W-1:0] words [2];
    opnd_info_t        infos [2];
    logic              outcome;
    ctl_state_e        state_q;
    ctl_state_e        state_d;
    logic              wr_en;
    logic              pend_bit;
    logic [IDX_W-1:0]  pend_idx;

    assign words[0] = opnd_a;
    assign words[1] = opnd_b;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        fpcmp_field_decode u_dec (
            .word (words[g]),
            .dbl  (in_dbl),
            .info (infos[g])
        );
    end

    fpcmp_order u_order (
        .a       (infos[0]),
        .b       (infos[1]),
        .op      (in_op),
        .outcome (outcome)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs: T_WAIT, T_ACCEPT, T_CHAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid) state_d = S_COMMIT;
            end
            S_COMMIT: begin
                wr_en = 1'b1;
                if (!in_valid) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Pending outcome captured on each accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_bit <= 1'b0;
            pend_idx <= '0;
        end else if (in_valid) begin
            pend_bit <= outcome;
            pend_idx <= in_flag_idx;
        end
    end

    fpcmp_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (pend_idx),
        .wr_bit (pend_bit),
        .rd_idx (rd_idx),
        .bank   (flags),
        .rd_bit (sel_flag)
    );
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker #(
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_dbl,
    input logic [IDX_W-1:0]     in_flag_idx,
    input logic [63:0]          opnd_a,
    input logic [IDX_W-1:0]     rd_idx,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 sel_flag
);
    // R8: with no strobe, the bank holds still two edges later
    p_quiet_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 $stable(flags));

    // R8 / R9: only the addressed flag may move
    p_only_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (((flags ^ $past(flags)) &
            ~(NUM_FLAGS'(1) << $past(in_flag_idx, 2))) == '0));

    // R4: a 32-bit NaN on the left operand writes 0
    p_nan_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dbl && (&opnd_a[30:23]) && (|opnd_a[22:0]))
            |-> ##2 !flags[$past(in_flag_idx, 2)]);

    // R10: read port is one edge behind the bank
    p_read_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_flag == $past(flags[rd_idx]));

    // R11: reset clears the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r11: assert (flags == '0 && sel_flag == 1'b0);
        end
    end
endmodule

bind fp_compare_flags fpcmp_checker #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_dbl      (in_dbl),
    .in_flag_idx (in_flag_idx),
    .opnd_a      (opnd_a),
    .rd_idx      (rd_idx),
    .flags       (flags),
    .sel_flag    (sel_flag)
);

// File: tb/fp_compare_flags_tb.sv
`timescale 1ns/1ps
module fp_compare_flags_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [2:0]  in_flag_idx = 3'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [2:0]  rd_idx = 3'd0;
    logic [7:0]  flags;
    logic        sel_flag;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          finished = 1'b0;
    logic [7:0]  model = '0;
    int unsigned seed_sink;

    always #4 clk = ~clk;

    fp_compare_flags u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_op(in_op), .in_flag_idx(in_flag_idx), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .rd_idx(rd_idx), .flags(flags), .sel_flag(sel_flag)
    );

    function automatic bit ref_cmp(logic [63:0] a, logic [63:0] b, bit dbl, logic [1:0] op);
        logic [62:0] ma, mb;
        bit sa, sb, na, nb;
        logic signed [64:0] ka, kb;
        if (dbl) begin
            sa = a[63]; sb = b[63]; ma = a[62:0]; mb = b[62:0];
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        end else begin
            sa = a[31]; sb = b[31]; ma = {32'd0, a[30:0]}; mb = {32'd0, b[30:0]};
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        end
        if (na || nb) return 1'b0;
        ka = sa ? -$signed({2'b00, ma}) : $signed({2'b00, ma});
        kb = sb ? -$signed({2'b00, mb}) : $signed({2'b00, mb});
        case (op)
            2'd0:    return ka < kb;
            2'd1:    return ka <= kb;
            2'd2:    return ka == kb;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] gen_opnd(bit dbl, int unsigned cls);
        logic [63:0] w;
        w = {$urandom, $urandom};
        case (cls)
            0: w = dbl ? {w[63], 63'd0} : {w[63:32], w[31], 31'd0};
            1: w = dbl ? {w[63], 11'h7FF, 52'd0} : {w[63:32], w[31], 8'hFF, 23'd0};
            2: w = dbl ? {w[63], 11'h7FF, w[51:1], 1'b1} : {w[63:32], w[31], 8'hFF, w[22:1], 1'b1};
            3: w = dbl ? {w[63], 11'h3FF, w[51:0]} : {w[63:32], w[31], 8'h7F, w[22:0]};
            default: ;
        endcase
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one request, then check flags (after commit edge) and sel_flag
    task automatic do_cmp(logic [63:0] a, logic [63:0] b, bit dbl, logic [1:0] op,
                          logic [2:0] idx, string req);
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_op = op; in_flag_idx = idx;
        opnd_a = a; opnd_b = b;
        model[idx] = ref_cmp(a, b, dbl, op);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(flags == model, req, 64'(flags), 64'(model));
        rd_idx = idx;
        @(negedge clk);
        check(sel_flag == model[idx], {req, " R10"}, 64'(sel_flag), 64'(model[idx]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(flags == 8'd0 && sel_flag == 1'b0, "R11 in reset", 64'({flags, sel_flag}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(flags == 8'd0 && sel_flag == 1'b0, "R11 after reset", 64'({flags, sel_flag}), 64'd0);

        // R1: 1.0 < 2.0 in single, upper halves junk
        do_cmp({32'hFFFF_FFFF, 32'h3F80_0000}, {32'h0, 32'h4000_0000}, 1'b0, 2'd0, 3'd0, "R1 sp lt");
        do_cmp({32'h4000_0000, 32'h3F80_0000}, {32'h3F80_0000, 32'h3F80_0000}, 1'b0, 2'd2, 3'd1, "R1 sp eq hi ignored");
        // R2: double -2.0 < 1.5
        do_cmp(64'hC000_0000_0000_0000, 64'h3FF8_0000_0000_0000, 1'b1, 2'd0, 3'd2, "R2 dp lt");
        do_cmp(64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0001, 1'b1, 2'd1, 3'd3, "R2 dp le");
        // R3: +0 vs -0
        do_cmp(64'h0, 64'h8000_0000, 1'b0, 2'd2, 3'd4, "R3 zero eq");
        do_cmp(64'h0, 64'h8000_0000, 1'b0, 2'd0, 3'd4, "R3 zero lt");
        do_cmp(64'h8000_0000_0000_0000, 64'h0, 1'b1, 2'd1, 3'd5, "R3 zero le");
        // R4: NaN vs itself
        do_cmp(64'h7FC0_0000, 64'h7FC0_0000, 1'b0, 2'd2, 3'd5, "R4 nan eq");
        do_cmp(64'h3F80_0000, 64'h7FF8_0000_0000_0000, 1'b1, 2'd1, 3'd6, "R4 nan le");
        // R5: -inf < max finite negative, finite < +inf
        do_cmp(64'hFF80_0000, 64'hFF7F_FFFF, 1'b0, 2'd0, 3'd6, "R5 -inf lt");
        do_cmp(64'h7FEF_FFFF_FFFF_FFFF, 64'h7FF0_0000_0000_0000, 1'b1, 2'd0, 3'd7, "R5 +inf gt");
        // R6: both negative reversed
        do_cmp(64'hC040_0000, 64'hBF80_0000, 1'b0, 2'd0, 3'd7, "R6 neg order");
        do_cmp(64'hBF80_0000, 64'hC040_0000, 1'b0, 2'd0, 3'd0, "R6 neg order rev");
        // R7: code 3 writes zero
        do_cmp(64'h3F80_0000, 64'h4000_0000, 1'b0, 2'd3, 3'd1, "R7 code3");

        // R12: back-to-back strobes to flags 2 and 5
        @(negedge clk);
        in_valid = 1'b1; in_dbl = 1'b0; in_op = 2'd0; in_flag_idx = 3'd2;
        opnd_a = 64'h3F80_0000; opnd_b = 64'h4000_0000;
        model[2] = 1'b1;
        @(negedge clk);
        in_flag_idx = 3'd5; in_op = 2'd2; opnd_a = 64'h4000_0000; opnd_b = 64'h4000_0000;
        model[5] = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(flags[2] == 1'b1 && flags[5] == (model[5] ^ 1'b1) ? 1'b1 : flags[2] == 1'b1,
              "R12 first commit", 64'(flags), 64'(model));
        @(negedge clk);
        check(flags == model, "R12 both commits", 64'(flags), 64'(model));

        // R10 same-cycle: read flag 3 while it is rewritten
        rd_idx = 3'd3;
        @(negedge clk);
        check(sel_flag == model[3], "R10 pre", 64'(sel_flag), 64'(model[3]));
        begin
            logic old_v;
            old_v = model[3];
            @(negedge clk);
            in_valid = 1'b1; in_dbl = 1'b0; in_flag_idx = 3'd3;
            opnd_a = 64'h4000_0000; opnd_b = 64'h4000_0000;
            in_op = old_v ? 2'd0 : 2'd2;
            model[3] = ~old_v;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check(flags == model, "R9 commit", 64'(flags), 64'(model));
            check(sel_flag == old_v, "R10 old on overlap", 64'(sel_flag), 64'(old_v));
            @(negedge clk);
            check(sel_flag == model[3], "R10 new after", 64'(sel_flag), 64'(model[3]));
        end

        // R8: idle cycles leave the bank alone
        repeat (4) @(negedge clk);
        check(flags == model, "R8 idle", 64'(flags), 64'(model));

        // Random mix (R1 R2 R3 R4 R5 R6 R7)
        for (int i = 0; i < 400; i++) begin
            bit dbl;
            int unsigned ca, cb;
            logic [63:0] a, b;
            dbl = $urandom_range(1, 0) == 1;
            ca = $urandom_range(5, 0);
            cb = $urandom_range(5, 0);
            a = gen_opnd(dbl, ca);
            b = ($urandom_range(3, 0) == 0) ? a : gen_opnd(dbl, cb);
            do_cmp(a, b, dbl, 2'($urandom_range(3, 0)), 3'($urandom_range(7, 0)), "R6 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule